// File: doc/BRIEF.md
# Bus Unit Lock Tracker

This block follows the lock state of one unit on a shared serial bus. A master can claim a unit by sending one of a small set of control-field codes. After that, the unit answers only that master's individual frames until the lock is dropped. The block watches the decoded control nibble, the sender's master address, the broadcast and slave-status-request indications, and the communication-end, frame-end and communication-enable flags. From these it keeps a lock flag and the address of the master that holds the lock.

The lock forms when a frame that carried a lock code ends cleanly: frame-end rises while communication-end is still low. The lock is released when the holding master sends a lock code again and communication-end then rises. Dropping communication-enable clears everything. A combinational acknowledge-permit output tells the receiver whether the frame now in progress may be acknowledged. While the unit is locked, that output filters frames by sender, but status requests and broadcasts always pass.

Top module: `bus_lock_tracker`

## Requirements
- R1: While `rst_ni` is low, `lock_o` is 0 and `lock_addr_o` is 0. With no lock held, `ack_permit_o` is 1.
- R2: If `ctrl_valid_i` arrives with a lock code while the unit is unlocked and the frame is not a broadcast, a later rising edge of `frame_end_i` with `comm_end_i` low sets `lock_o` at that clock edge. At the same edge, `lock_addr_o` takes the `master_addr_i` sampled with the code and then holds that value while locked.
- R3: A pending lock code does not lock the unit if `comm_end_i` is high when `frame_end_i` rises. That frame-end edge discards the pending request.
- R4: Only control nibbles 4'h3, 4'h6, 4'hA and 4'hB request a lock or a release. Any other nibble cancels a pending request and never changes `lock_o`.
- R5: A lock code with `broadcast_i` high neither locks nor unlocks the unit.
- R6: While locked, a lock code from the holding master (`master_addr_i == lock_addr_o`), followed by a rising edge of `comm_end_i`, clears `lock_o` and `lock_addr_o` at that clock edge.
- R7: While locked, a lock code from any other master is not taken as a release.
- R8: When `comm_en_i` is low at a clock edge, `lock_o`, `lock_addr_o` and any pending request are cleared, and no lock can form.
- R9: While locked, an individual frame that is not a status request and comes from a master other than the holder has `ack_permit_o` = 0. A frame from the holder has `ack_permit_o` = 1.
- R10: When `status_req_i` is high, `ack_permit_o` is 1 whether or not the unit is locked.
- R11: When the unit is unlocked, `ack_permit_o` is 1 for every frame. When `broadcast_i` is high, `ack_permit_o` is 1 in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| comm_en_i | input | 1 | Communication enable; low clears the lock |
| ctrl_valid_i | input | 1 | One-cycle strobe: control field received |
| ctrl_nibble_i | input | 4 | Received control-field value |
| broadcast_i | input | 1 | The current frame is a broadcast |
| master_addr_i | input | ADDR_W | Sender's master address |
| status_req_i | input | 1 | The current frame is a slave status request |
| comm_end_i | input | 1 | Communication-end flag |
| frame_end_i | input | 1 | Frame-end flag |
| lock_o | output | 1 | Lock status |
| lock_addr_o | output | ADDR_W | Address of the master holding the lock |
| ack_permit_o | output | 1 | The current frame may be acknowledged |

## Verification
The hardest state to reach is a locked unit whose pending request meets the wrong flag edge. Examples are a release code from a foreign master followed by a communication-end edge, and a lock code whose frame-end edge arrives while communication-end is already high. The stimulus first builds a genuine lock from a known address. It then sends release attempts that are almost valid, varying one element at a time: the sender, the broadcast bit, or the order of the flags. After each attempt it checks both the lock flag and the permit filter. A sweep over all sixteen control values then confirms that only the four lock codes take effect.

// File: rtl/bus_lock_pkg.sv
package bus_lock_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_SET  = 2'd1,
    REQ_REL  = 2'd2
  } lock_req_e;

  localparam int unsigned CTRL_W = 4;

  function automatic logic is_lock_code(input logic [CTRL_W-1:0] code);
    return (code == 4'h3) || (code == 4'h6) || (code == 4'hA) || (code == 4'hB);
  endfunction
endpackage

// File: rtl/bus_lock_edge.sv
module bus_lock_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_edge
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~prev_q;
  end
endmodule

// File: rtl/bus_lock_req.sv
module bus_lock_req
  import bus_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              comm_en_i,
  input  logic              ctrl_valid_i,
  input  logic [CTRL_W-1:0] ctrl_nibble_i,
  input  logic              broadcast_i,
  input  logic [ADDR_W-1:0] master_addr_i,
  input  logic              locked_i,
  input  logic [ADDR_W-1:0] lock_addr_i,
  input  logic              fe_rise_i,
  input  logic              ce_rise_i,
  output lock_req_e         req_o,
  output logic [ADDR_W-1:0] req_addr_o
);
  lock_req_e         req_q, req_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    req_d  = req_q;
    addr_d = addr_q;
    if (!comm_en_i) begin
      req_d = REQ_NONE;
    end else if (ctrl_valid_i) begin
      req_d = REQ_NONE;
      if (is_lock_code(ctrl_nibble_i) && !broadcast_i) begin
        if (!locked_i) begin
          req_d  = REQ_SET;
          addr_d = master_addr_i;
        end else if (master_addr_i == lock_addr_i) begin
          req_d = REQ_REL;
        end
      end
    end else if ((req_q == REQ_SET && fe_rise_i) || (req_q == REQ_REL && ce_rise_i)) begin
      req_d = REQ_NONE;  // request consumed by its edge
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= REQ_NONE;
      addr_q <= '0;
    end else begin
      req_q  <= req_d;
      addr_q <= addr_d;
    end
  end

  assign req_o      = req_q;
  assign req_addr_o = addr_q;
endmodule

// File: rtl/bus_lock_state.sv
module bus_lock_state
  import bus_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              comm_en_i,
  input  lock_req_e         req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              comm_end_i,
  input  logic              fe_rise_i,
  input  logic              ce_rise_i,
  output logic              locked_o,
  output logic [ADDR_W-1:0] lock_addr_o
);
  logic              locked_q;
  logic [ADDR_W-1:0] addr_q;
  logic              do_set, do_rel;

  assign do_set = (req_i == REQ_SET) && fe_rise_i && !comm_end_i;
  assign do_rel = (req_i == REQ_REL) && ce_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      addr_q   <= '0;
    end else if (!comm_en_i) begin
      locked_q <= 1'b0;
      addr_q   <= '0;
    end else if (do_set) begin
      locked_q <= 1'b1;
      addr_q   <= req_addr_i;
    end else if (do_rel) begin
      locked_q <= 1'b0;
      addr_q   <= '0;
    end
  end

  assign locked_o    = locked_q;
  assign lock_addr_o = addr_q;
endmodule

// File: rtl/bus_lock_ack.sv
module bus_lock_ack #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              locked_i,
  input  logic [ADDR_W-1:0] lock_addr_i,
  input  logic [ADDR_W-1:0] master_addr_i,
  input  logic              broadcast_i,
  input  logic              status_req_i,
  output logic              permit_o
);
  logic from_holder;
  assign from_holder = (master_addr_i == lock_addr_i);
  assign permit_o    = !locked_i || broadcast_i || status_req_i || from_holder;
endmodule

// File: rtl/bus_lock_tracker.sv
module bus_lock_tracker
  import bus_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              comm_en_i,
  input  logic              ctrl_valid_i,
  input  logic [3:0]        ctrl_nibble_i,
  input  logic              broadcast_i,
  input  logic [ADDR_W-1:0] master_addr_i,
  input  logic              status_req_i,
  input  logic              comm_end_i,
  input  logic              frame_end_i,
  output logic              lock_o,
  output logic [ADDR_W-1:0] lock_addr_o,
  output logic              ack_permit_o
);
  localparam int unsigned FE = 0;
  localparam int unsigned CE = 1;

  logic [1:0]        rise;
  lock_req_e         req;
  logic [ADDR_W-1:0] req_addr;
  logic              locked;
  logic [ADDR_W-1:0] lock_addr;

  bus_lock_edge #(.N(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({comm_end_i, frame_end_i}),
    .rise_o (rise)
  );

  bus_lock_req #(.ADDR_W(ADDR_W)) u_req (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .comm_en_i     (comm_en_i),
    .ctrl_valid_i  (ctrl_valid_i),
    .ctrl_nibble_i (ctrl_nibble_i),
    .broadcast_i   (broadcast_i),
    .master_addr_i (master_addr_i),
    .locked_i      (locked),
    .lock_addr_i   (lock_addr),
    .fe_rise_i     (rise[FE]),
    .ce_rise_i     (rise[CE]),
    .req_o         (req),
    .req_addr_o    (req_addr)
  );

  bus_lock_state #(.ADDR_W(ADDR_W)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .comm_en_i   (comm_en_i),
    .req_i       (req),
    .req_addr_i  (req_addr),
    .comm_end_i  (comm_end_i),
    .fe_rise_i   (rise[FE]),
    .ce_rise_i   (rise[CE]),
    .locked_o    (locked),
    .lock_addr_o (lock_addr)
  );

  bus_lock_ack #(.ADDR_W(ADDR_W)) u_ack (
    .locked_i      (locked),
    .lock_addr_i   (lock_addr),
    .master_addr_i (master_addr_i),
    .broadcast_i   (broadcast_i),
    .status_req_i  (status_req_i),
    .permit_o      (ack_permit_o)
  );

  assign lock_o      = locked;
  assign lock_addr_o = lock_addr;
endmodule

// File: rtl/bus_lock_tracker_chk.sv
module bus_lock_tracker_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              comm_en_i,
  input logic              broadcast_i,
  input logic [ADDR_W-1:0] master_addr_i,
  input logic              status_req_i,
  input logic              comm_end_i,
  input logic              frame_end_i,
  input logic              lock_o,
  input logic [ADDR_W-1:0] lock_addr_o,
  input logic              ack_permit_o
);
  // R2
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(frame_end_i) && !$past(comm_end_i) && $past(comm_en_i));

  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o && $past(lock_o) |-> $stable(lock_addr_o));

  // R6
  unlock_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> !$past(comm_en_i) || $past(comm_end_i));

  // R8
  comm_en_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !comm_en_i |=> !lock_o && (lock_addr_o == '0));

  // R9
  foreign_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o && !broadcast_i && !status_req_i && (master_addr_i != lock_addr_o) |-> !ack_permit_o);

  // R10
  status_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_req_i |-> ack_permit_o);

  // R11
  unlocked_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_o || broadcast_i |-> ack_permit_o);
endmodule

bind bus_lock_tracker bus_lock_tracker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .comm_en_i     (comm_en_i),
  .broadcast_i   (broadcast_i),
  .master_addr_i (master_addr_i),
  .status_req_i  (status_req_i),
  .comm_end_i    (comm_end_i),
  .frame_end_i   (frame_end_i),
  .lock_o        (lock_o),
  .lock_addr_o   (lock_addr_o),
  .ack_permit_o  (ack_permit_o)
);

// File: tb/bus_lock_tracker_test.sv
`timescale 1ns/1ps
module bus_lock_tracker_test;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          comm_en = 1'b1;
  logic          ctrl_valid = 1'b0;
  logic [3:0]    ctrl = 4'h0;
  logic          bc = 1'b0;
  logic [AW-1:0] maddr = '0;
  logic          sreq = 1'b0;
  logic          comm_end = 1'b0;
  logic          frame_end = 1'b0;
  logic          lock;
  logic [AW-1:0] lock_addr;
  logic          permit;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  bus_lock_tracker #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .comm_en_i(comm_en), .ctrl_valid_i(ctrl_valid),
    .ctrl_nibble_i(ctrl), .broadcast_i(bc), .master_addr_i(maddr),
    .status_req_i(sreq), .comm_end_i(comm_end), .frame_end_i(frame_end),
    .lock_o(lock), .lock_addr_o(lock_addr), .ack_permit_o(permit)
  );

  // behavioural reference: pend 0 none, 1 lock wanted, 2 release wanted
  int          m_pend;
  int          m_lock;
  int unsigned m_addr, m_paddr;
  bit          m_pfe, m_pce;

  function automatic bit code_ok(int c);
    return c == 3 || c == 6 || c == 10 || c == 11;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_lock = 0; m_addr = 0; m_paddr = 0; m_pfe = 0; m_pce = 0;
    end else begin
      bit fe_up, ce_up, used;
      int nl, np;
      int unsigned na, npa;
      fe_up = frame_end && !m_pfe;
      ce_up = comm_end && !m_pce;
      nl = m_lock; na = m_addr; np = m_pend; npa = m_paddr; used = 0;
      if (!comm_en) begin
        nl = 0; na = 0; np = 0;
      end else begin
        if (m_pend == 1 && fe_up) begin
          used = 1;
          if (!comm_end) begin nl = 1; na = m_paddr; end
        end
        if (m_pend == 2 && ce_up) begin used = 1; nl = 0; na = 0; end
        if (ctrl_valid) begin
          np = 0;
          if (code_ok(int'(ctrl)) && !bc) begin
            if (m_lock == 0) begin np = 1; npa = maddr; end
            else if (maddr == m_addr) np = 2;
          end
        end else if (used) np = 0;
      end
      m_lock = nl; m_addr = na; m_pend = np; m_paddr = npa;
      m_pfe = frame_end; m_pce = comm_end;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference, at the falling edge
  task automatic compare();
    int exp_p;
    exp_p = (m_lock == 0 || bc || sreq || maddr == m_addr) ? 1 : 0;
    check(cur_req, "lock_o", int'(lock), m_lock);
    check(cur_req, "lock_addr_o", int'(lock_addr), int'(m_addr));
    check(cur_req, "ack_permit_o", int'(permit), exp_p);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic send_ctrl(input logic [3:0] c, input logic b, input logic [AW-1:0] a);
    ctrl = c; bc = b; maddr = a; ctrl_valid = 1'b1;
    cyc();
    ctrl_valid = 1'b0;
    cyc();
  endtask

  task automatic end_frame(input logic ce);
    frame_end = 1'b1; comm_end = ce;
    cyc();
    frame_end = 1'b0; comm_end = 1'b0;
    cyc();
  endtask

  task automatic end_comm();
    comm_end = 1'b1;
    cyc();
    comm_end = 1'b0;
    cyc();
  endtask

  task automatic drop_en();
    comm_en = 1'b0;
    cyc();
    comm_en = 1'b1;
    cyc();
  endtask

  initial begin
    #1000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset values
    #1;
    check("R1", "lock in reset", int'(lock), 0);
    check("R1", "addr in reset", int'(lock_addr), 0);
    check("R1", "permit in reset", int'(permit), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();

    // R11: unlocked permits everything
    cur_req = "R11";
    maddr = 12'h045; cyc();
    bc = 1'b1; cyc(); bc = 1'b0;
    check("R11", "permit unlocked", int'(permit), 1);

    // R4: all codes, lock forms only for the four lock codes
    cur_req = "R4";
    for (int c = 0; c < 16; c++) begin
      send_ctrl(4'(c), 1'b0, 12'h200 + AW'(c));
      end_frame(1'b0);
      check("R4", $sformatf("lock after code %0h", c), int'(lock), code_ok(c) ? 1 : 0);
      drop_en();
    end

    // R4: non-code after a lock code cancels the request
    send_ctrl(4'h3, 1'b0, 12'h011);
    send_ctrl(4'h5, 1'b0, 12'h011);
    end_frame(1'b0);
    check("R4", "cancelled request", int'(lock), 0);

    // R5: broadcast lock code ignored
    cur_req = "R5";
    send_ctrl(4'h3, 1'b1, 12'h123);
    end_frame(1'b0);
    check("R5", "broadcast lock", int'(lock), 0);

    // R3: comm_end high at frame end
    cur_req = "R3";
    send_ctrl(4'h6, 1'b0, 12'h123);
    end_frame(1'b1);
    check("R3", "lock with comm_end high", int'(lock), 0);
    end_frame(1'b0);
    check("R3", "request discarded", int'(lock), 0);

    // R2: real lock, address latched
    cur_req = "R2";
    send_ctrl(4'hA, 1'b0, 12'h123);
    maddr = 12'h777;
    frame_end = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2", "lock at edge", int'(lock), 1);
    check("R2", "addr at edge", int'(lock_addr), 'h123);
    compare();
    frame_end = 1'b0;
    cyc();

    // R9 / R10 / R11 filtering while locked
    cur_req = "R9";
    maddr = 12'h045; bc = 1'b0; sreq = 1'b0; cyc();
    check("R9", "foreign blocked", int'(permit), 0);
    maddr = 12'h123; cyc();
    check("R9", "holder permitted", int'(permit), 1);
    cur_req = "R10";
    maddr = 12'h045; sreq = 1'b1; cyc();
    check("R10", "status req permitted", int'(permit), 1);
    sreq = 1'b0;
    cur_req = "R11";
    bc = 1'b1; cyc();
    check("R11", "broadcast permitted", int'(permit), 1);
    bc = 1'b0;

    // R7: foreign release ignored
    cur_req = "R7";
    send_ctrl(4'h3, 1'b0, 12'h045);
    end_comm();
    check("R7", "foreign release", int'(lock), 1);
    check("R7", "addr kept", int'(lock_addr), 'h123);

    // R5: broadcast release ignored
    cur_req = "R5";
    send_ctrl(4'hB, 1'b1, 12'h123);
    end_comm();
    check("R5", "broadcast release", int'(lock), 1);

    // R6: holder release
    cur_req = "R6";
    send_ctrl(4'hB, 1'b0, 12'h123);
    frame_end = 1'b1; cyc(); frame_end = 1'b0; cyc();
    check("R6", "no release at frame end", int'(lock), 1);
    comm_end = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R6", "released", int'(lock), 0);
    check("R6", "addr cleared", int'(lock_addr), 0);
    compare();
    comm_end = 1'b0; cyc();

    // R8: comm_en low clears lock and blocks forming
    cur_req = "R8";
    send_ctrl(4'hB, 1'b0, 12'hFFF);
    end_frame(1'b0);
    check("R8", "locked before clear", int'(lock), 1);
    comm_en = 1'b0;
    cyc();
    check("R8", "cleared lock", int'(lock), 0);
    check("R8", "cleared addr", int'(lock_addr), 0);
    send_ctrl(4'h6, 1'b0, 12'h0AA);
    end_frame(1'b0);
    check("R8", "no lock while disabled", int'(lock), 0);
    comm_en = 1'b1;
    cyc();
    end_frame(1'b0);
    check("R8", "pending dropped", int'(lock), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule